// File: doc/BRIEF.md
# Polyphase Scaler Coefficient Store

This block holds the filter coefficients of a polyphase scaler with four channels: luma vertical, chroma vertical, luma horizontal and chroma horizontal. Software loads them through two write strobes. A select write latches a channel, a phase and a tap-pair index. A data write then stores up to two coefficients at that location, the even tap and the odd tap, and each of the two has its own enable. Only phases 0 to 32 of the 64 are held in storage. The datapath asks for phases 33 to 63 and the block rebuilds them from the stored half, with the tap order reversed.

Storage has two banks. Software always writes the shadow bank and the datapath always reads the active bank. Software first asks for a swap with an update-request pulse, and the swap takes place at the next frame-start pulse. The write side is behind a power gate: the memory powers up a fixed number of cycles after the power-disable input is raised. A write that arrives while the memory is gated is discarded and raises a sticky error flag.

The datapath read port is a valid/ready stream with a latency of one clock. A request is taken while `rd_ready` is high, and `rd_ready` equals `!rs_valid || rs_ready`. The response stays on `rs_*`, unchanged, until it is taken with `rs_ready`. The result of a request taken in the same cycle replaces it.

Top module: `scl_coef_store`

## Requirements
- R1: A data write stores `wr_even` at tap 2*pair and `wr_odd` at tap 2*pair+1 of the selected channel and phase in the shadow bank. A coefficient whose enable is low leaves its slot unchanged. The select write is registered, so a data write must follow it by at least one cycle.
- R2: A request for phase 0..32, taken on a clock edge, returns the active-bank coefficient for (channel, phase, tap) on `rs_coef`, with `rs_valid` high after that edge.
- R3: A request for phase p in 33..63 returns the stored coefficient of phase 64-p at tap (taps-1-k).
- R4: `cfg_taps[2c+1:2c]` holds taps-1 for channel c, where c is 0 luma-vertical, 1 chroma-vertical, 2 luma-horizontal, 3 chroma-horizontal. A channel with one tap returns `rs_bypass`=1 and coefficient 0. A tap index at or above the tap count returns 0 with `rs_bypass`=0.
- R5: Writes never change what the datapath reads until a bank swap.
- R6: `upd_req` sets `upd_pending`. A `frame_start` seen while `upd_pending` is set toggles `active_bank`, and `upd_pending` then clears unless `upd_req` is high in the same cycle. A `frame_start` seen without a pending request changes nothing.
- R7: `pwr_gated` is 1 out of reset. It falls PWR_DLY clock edges after `pwr_dis` is first sampled high, and it rises on the first edge that samples `pwr_dis` low.
- R8: A data write is discarded when it arrives while `pwr_gated` is 1 or when the selected phase is above 32. Either case sets `wr_err`, which stays set until reset.
- R9: While `rs_valid` is 1 and `rs_ready` is 0, `rd_ready` is 0 and `rs_coef`/`rs_bypass` hold their values.
- R10: Reset gives `active_bank`=0, `upd_pending`=0, `wr_err`=0, `rs_valid`=0, and every stored coefficient 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_taps | input | 8 | Per-channel tap count minus one |
| sel_we | input | 1 | Select write strobe |
| sel_ch | input | 2 | Selected channel |
| sel_phase | input | 6 | Selected phase |
| sel_pair | input | 1 | Selected tap-pair index |
| wr_we | input | 1 | Data write strobe |
| wr_even | input | 16 | Even-tap coefficient |
| wr_even_en | input | 1 | Store even coefficient |
| wr_odd | input | 16 | Odd-tap coefficient |
| wr_odd_en | input | 1 | Store odd coefficient |
| pwr_dis | input | 1 | Power-gating disable request |
| pwr_gated | output | 1 | Memory gated status (0 = powered) |
| upd_req | input | 1 | Request bank swap |
| frame_start | input | 1 | Frame boundary pulse |
| upd_pending | output | 1 | Swap requested, not yet done |
| active_bank | output | 1 | Bank the datapath reads |
| wr_err | output | 1 | Sticky dropped-write flag |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_ch | input | 2 | Read channel |
| rd_phase | input | 6 | Read phase 0..63 |
| rd_tap | input | 2 | Read tap index |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response taken |
| rs_coef | output | 16 | Coefficient (signed) |
| rs_bypass | output | 1 | Channel has one tap |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any other activity. They also assume that `frame_start`, `upd_req` and the write strobes are single-cycle pulses. The stimulus drives every input on the falling edge and issues each strobe for exactly one cycle. It writes every stored phase and pair of every channel and reads every channel, phase and tap back, and it uses tap counts of 4, 2, 4 and 1 so that the mirroring, the out-of-range tap and the bypass case all appear in one sweep.

// File: rtl/scl_coef_pkg.sv
package scl_coef_pkg;
  localparam int CH_N = 4;
  localparam int CH_W = 2;

  typedef enum logic [CH_W-1:0] {
    CH_LUMA_V   = 2'd0,
    CH_CHROMA_V = 2'd1,
    CH_LUMA_H   = 2'd2,
    CH_CHROMA_H = 2'd3
  } scl_ch_e;
endpackage

// File: rtl/scl_pwr_gate.sv
module scl_pwr_gate #(
  parameter int PWR_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dis,
  output logic gated
);
  localparam int CW = $clog2(PWR_DLY + 1);
  localparam logic [CW-1:0] DLY = CW'(PWR_DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!pwr_dis)     cnt <= '0;
    else if (cnt != DLY)   cnt <= cnt + 1'b1;
  end

  assign gated = (cnt != DLY);

  // R7: dropping the disable request re-gates on the next edge
  a_r7_regate: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dis |=> gated);
  // R7: powered state persists while the request stays high
  a_r7_stay_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated && pwr_dis) |=> !gated);
endmodule

// File: rtl/scl_coef_rdmap.sv
module scl_coef_rdmap
  import scl_coef_pkg::*;
#(
  parameter int NUM_PHASES = 64,
  parameter int TAP_W      = 2,
  parameter int PH_W       = 6
) (
  input  logic [CH_N*TAP_W-1:0] cfg_taps,
  input  logic [CH_W-1:0]       ch,
  input  logic [PH_W-1:0]       phase,
  input  logic [TAP_W-1:0]      tap,
  output logic [PH_W-1:0]       st_phase,
  output logic [TAP_W-1:0]      st_tap,
  output logic                  zero,
  output logic                  bypass
);
  localparam logic [PH_W:0]   NPH = (PH_W+1)'(NUM_PHASES);
  localparam logic [PH_W-1:0] MID = PH_W'(NUM_PHASES / 2);

  logic [TAP_W-1:0] taps_m1;
  logic             mirror;
  logic [PH_W:0]    refl;

  always_comb begin
    taps_m1  = cfg_taps[ch*TAP_W +: TAP_W];
    mirror   = (phase > MID);
    refl     = NPH - {1'b0, phase};
    st_phase = mirror ? refl[PH_W-1:0] : phase;
    st_tap   = mirror ? (taps_m1 - tap) : tap;
    bypass   = (taps_m1 == '0);
    zero     = bypass || (tap > taps_m1);
  end
endmodule

// File: rtl/scl_coef_bank.sv
module scl_coef_bank
  import scl_coef_pkg::*;
#(
  parameter int SPH      = 33,
  parameter int MAX_TAPS = 4,
  parameter int COEF_W   = 16,
  parameter int PH_W     = 6,
  parameter int TAP_W    = 2,
  parameter int PAIR_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [PH_W-1:0]   wr_ph,
  input  logic [PAIR_W-1:0] wr_pair,
  input  logic [COEF_W-1:0] wr_even,
  input  logic              wr_even_en,
  input  logic [COEF_W-1:0] wr_odd,
  input  logic              wr_odd_en,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [PH_W-1:0]   rd_ph,
  input  logic [TAP_W-1:0]  rd_tap,
  output logic [COEF_W-1:0] rd_coef
);
  logic [COEF_W-1:0] mem [2][CH_N][SPH][MAX_TAPS];
  logic [TAP_W-1:0]  tap_e, tap_o;
  logic              wb;

  assign tap_e = {wr_pair, 1'b0};
  assign tap_o = {wr_pair, 1'b1};
  assign wb    = ~active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < CH_N; c++)
          for (int p = 0; p < SPH; p++)
            for (int k = 0; k < MAX_TAPS; k++)
              mem[b][c][p][k] <= '0;
    end else if (wr_en) begin
      if (wr_even_en) mem[wb][wr_ch][wr_ph][tap_e] <= wr_even;
      if (wr_odd_en)  mem[wb][wr_ch][wr_ph][tap_o] <= wr_odd;
    end
  end

  assign rd_coef = mem[active][rd_ch][rd_ph][rd_tap];

  // R5: a write never disturbs the coefficient the active bank presents
  a_r5_shadow_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $stable(active) && $stable(rd_ch) && $stable(rd_ph) && $stable(rd_tap))
      |=> ($stable(active) && $stable(rd_ch) && $stable(rd_ph) && $stable(rd_tap))
          -> $stable(rd_coef));
endmodule

// File: rtl/scl_coef_store.sv
module scl_coef_store
  import scl_coef_pkg::*;
#(
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 4,
  parameter int COEF_W     = 16,
  parameter int PWR_DLY    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CH_N*$clog2(MAX_TAPS)-1:0] cfg_taps,
  input  logic                          sel_we,
  input  logic [CH_W-1:0]               sel_ch,
  input  logic [$clog2(NUM_PHASES)-1:0] sel_phase,
  input  logic [$clog2(MAX_TAPS)-2:0]   sel_pair,
  input  logic                          wr_we,
  input  logic [COEF_W-1:0]             wr_even,
  input  logic                          wr_even_en,
  input  logic [COEF_W-1:0]             wr_odd,
  input  logic                          wr_odd_en,
  input  logic                          pwr_dis,
  output logic                          pwr_gated,
  input  logic                          upd_req,
  input  logic                          frame_start,
  output logic                          upd_pending,
  output logic                          active_bank,
  output logic                          wr_err,
  input  logic                          rd_valid,
  output logic                          rd_ready,
  input  logic [CH_W-1:0]               rd_ch,
  input  logic [$clog2(NUM_PHASES)-1:0] rd_phase,
  input  logic [$clog2(MAX_TAPS)-1:0]   rd_tap,
  output logic                          rs_valid,
  input  logic                          rs_ready,
  output logic [COEF_W-1:0]             rs_coef,
  output logic                          rs_bypass
);
  localparam int PH_W   = $clog2(NUM_PHASES);
  localparam int TAP_W  = $clog2(MAX_TAPS);
  localparam int PAIR_W = TAP_W - 1;
  localparam int SPH    = NUM_PHASES / 2 + 1;
  localparam logic [PH_W-1:0] PH_MID = PH_W'(NUM_PHASES / 2);

  // select register
  scl_ch_e           sel_ch_q;
  logic [PH_W-1:0]   sel_ph_q;
  logic [PAIR_W-1:0] sel_pair_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_ch_q   <= CH_LUMA_V;
      sel_ph_q   <= '0;
      sel_pair_q <= '0;
    end else if (sel_we) begin
      sel_ch_q   <= scl_ch_e'(sel_ch);
      sel_ph_q   <= sel_phase;
      sel_pair_q <= sel_pair;
    end
  end

  // power gate
  scl_pwr_gate #(.PWR_DLY(PWR_DLY)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pwr_dis(pwr_dis), .gated(pwr_gated)
  );

  // write qualification and sticky error
  logic wr_bad, wr_ok;
  assign wr_bad = pwr_gated || (sel_ph_q > PH_MID);
  assign wr_ok  = wr_we && !wr_bad;

  always_ff @(posedge clk) begin
    if (!rst_n)                wr_err <= 1'b0;
    else if (wr_we && wr_bad)  wr_err <= 1'b1;
  end

  // bank swap control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_bank <= 1'b0;
      upd_pending <= 1'b0;
    end else begin
      if (frame_start && upd_pending) active_bank <= ~active_bank;
      upd_pending <= (upd_pending && !frame_start) || upd_req;
    end
  end

  // read address mapping
  logic [PH_W-1:0]   st_phase;
  logic [TAP_W-1:0]  st_tap;
  logic              rd_zero, rd_byp;
  logic [COEF_W-1:0] raw_coef;

  scl_coef_rdmap #(.NUM_PHASES(NUM_PHASES), .TAP_W(TAP_W), .PH_W(PH_W)) u_map (
    .cfg_taps(cfg_taps), .ch(rd_ch), .phase(rd_phase), .tap(rd_tap),
    .st_phase(st_phase), .st_tap(st_tap), .zero(rd_zero), .bypass(rd_byp)
  );

  scl_coef_bank #(
    .SPH(SPH), .MAX_TAPS(MAX_TAPS), .COEF_W(COEF_W),
    .PH_W(PH_W), .TAP_W(TAP_W), .PAIR_W(PAIR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .active(active_bank),
    .wr_en(wr_ok), .wr_ch(sel_ch_q), .wr_ph(sel_ph_q), .wr_pair(sel_pair_q),
    .wr_even(wr_even), .wr_even_en(wr_even_en),
    .wr_odd(wr_odd), .wr_odd_en(wr_odd_en),
    .rd_ch(rd_ch), .rd_ph(st_phase), .rd_tap(st_tap), .rd_coef(raw_coef)
  );

  // response stage
  logic rd_acc;
  assign rd_ready = !rs_valid || rs_ready;
  assign rd_acc   = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_coef   <= '0;
      rs_bypass <= 1'b0;
    end else if (rd_acc) begin
      rs_valid  <= 1'b1;
      rs_coef   <= rd_zero ? '0 : raw_coef;
      rs_bypass <= rd_byp;
    end else if (rs_ready) begin
      rs_valid  <= 1'b0;
    end
  end

  // R6: a pending swap at frame start toggles the active bank
  a_r6_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && upd_pending) |=> (active_bank != $past(active_bank)));
  // R6: no swap without a pending request at a frame boundary
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && upd_pending) |=> $stable(active_bank));
  // R6: the pending flag clears after it is consumed
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && upd_pending && !upd_req) |=> !upd_pending);
  // R8: a write into gated memory raises the error flag
  a_r8_gated_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_we && pwr_gated) |=> wr_err);
  // R8: the error flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
  // R9: a stalled response holds its payload
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_coef) && $stable(rs_bypass)));
  // R4: a bypassed channel presents a zero coefficient
  a_r4_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_bypass) |-> (rs_coef == '0));
endmodule

// File: tb/tb_scl_coef_store.sv
`timescale 1ns/1ps
module tb_scl_coef_store;
  localparam int PWR_DLY = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_taps;
  logic        sel_we, wr_we, wr_even_en, wr_odd_en;
  logic [1:0]  sel_ch, rd_ch, rd_tap;
  logic [5:0]  sel_phase, rd_phase;
  logic [0:0]  sel_pair;
  logic [15:0] wr_even, wr_odd, rs_coef;
  logic        pwr_dis, pwr_gated, upd_req, frame_start, upd_pending, active_bank;
  logic        wr_err, rd_valid, rd_ready, rs_valid, rs_ready, rs_bypass;

  always #4 clk = ~clk;

  scl_coef_store #(.PWR_DLY(PWR_DLY)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_taps(cfg_taps),
    .sel_we(sel_we), .sel_ch(sel_ch), .sel_phase(sel_phase), .sel_pair(sel_pair),
    .wr_we(wr_we), .wr_even(wr_even), .wr_even_en(wr_even_en),
    .wr_odd(wr_odd), .wr_odd_en(wr_odd_en),
    .pwr_dis(pwr_dis), .pwr_gated(pwr_gated),
    .upd_req(upd_req), .frame_start(frame_start),
    .upd_pending(upd_pending), .active_bank(active_bank), .wr_err(wr_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_ch(rd_ch),
    .rd_phase(rd_phase), .rd_tap(rd_tap),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_coef(rs_coef), .rs_bypass(rs_bypass)
  );

  int n_chk = 0;
  int n_bad = 0;
  int taps_of [4] = '{4, 2, 4, 1};
  logic [15:0] mdl [2][4][33][4];
  logic act;
  logic powered;

  task automatic chk(string req, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, a, e);
    end
  endtask

  function automatic logic [15:0] pat(int g, int t, int p, int k);
    logic [15:0] v;
    v = 16'(g * 7919 + t * 1031 + p * 37 + k * 5 + 1);
    if (g == 2) v = v ^ 16'h8000;
    return v;
  endfunction

  task automatic clear_model();
    for (int b = 0; b < 2; b++)
      for (int t = 0; t < 4; t++)
        for (int p = 0; p < 33; p++)
          for (int k = 0; k < 4; k++)
            mdl[b][t][p][k] = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel_we = 0; wr_we = 0; pwr_dis = 0; upd_req = 0;
    frame_start = 0; rd_valid = 0; rs_ready = 1;
    sel_ch = 0; sel_phase = 0; sel_pair = 0; wr_even = 0; wr_odd = 0;
    wr_even_en = 0; wr_odd_en = 0; rd_ch = 0; rd_phase = 0; rd_tap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    act = 1'b0;
    powered = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(int t, int ph, int pr, logic [15:0] ev, logic ee,
                    logic [15:0] od, logic oe);
    @(negedge clk);
    sel_we = 1; sel_ch = 2'(t); sel_phase = 6'(ph); sel_pair = 1'(pr);
    @(negedge clk);
    sel_we = 0; wr_we = 1; wr_even = ev; wr_even_en = ee; wr_odd = od; wr_odd_en = oe;
    @(negedge clk);
    wr_we = 0;
    if (powered && ph <= 32) begin
      if (ee) mdl[!act][t][ph][2*pr]   = ev;
      if (oe) mdl[!act][t][ph][2*pr+1] = od;
    end
  endtask

  task automatic power_up(string req);
    int cyc = 0;
    pwr_dis = 1;
    while (pwr_gated && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    chk(req, 32'(cyc), 32'(PWR_DLY));
    powered = 1'b1;
  endtask

  task automatic flip();
    @(negedge clk); upd_req = 1;
    @(negedge clk); upd_req = 0;
    chk("R6 pending set", 32'(upd_pending), 32'd1);
    frame_start = 1;
    @(negedge clk); frame_start = 0;
    act = !act;
    chk("R6 bank toggled", 32'(active_bank), 32'(act));
    chk("R6 pending cleared", 32'(upd_pending), 32'd0);
  endtask

  task automatic rd_chk(string req, int t, int ph, int k);
    int nt, sp, st;
    logic [15:0] ec;
    logic eb;
    nt = taps_of[t];
    eb = (nt == 1);
    if (eb || k >= nt) ec = '0;
    else begin
      sp = (ph <= 32) ? ph : 64 - ph;
      st = (ph <= 32) ? k : nt - 1 - k;
      ec = mdl[act][t][sp][st];
    end
    rd_valid = 1; rd_ch = 2'(t); rd_phase = 6'(ph); rd_tap = 2'(k);
    @(negedge clk);
    rd_valid = 0;
    chk({req, " valid"}, 32'(rs_valid), 32'd1);
    chk({req, " coef"}, 32'(rs_coef), 32'(ec));
    chk({req, " bypass"}, 32'(rs_bypass), 32'(eb));
    @(negedge clk);
  endtask

  task automatic sweep_write(int g);
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < 33; p++)
        for (int pr = 0; pr < 2; pr++)
          wr(t, p, pr, pat(g, t, p, 2*pr), 1'b1, pat(g, t, p, 2*pr+1), 1'b1);
  endtask

  task automatic sweep_read();
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < 64; p++)
        for (int k = 0; k < 4; k++)
          rd_chk(p <= 32 ? "R2/R4 direct" : "R3/R4 mirror", t, p, k);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    cfg_taps = {2'd0, 2'd3, 2'd1, 2'd3};
    do_reset();
    // R10 reset state
    chk("R10 active_bank", 32'(active_bank), 32'd0);
    chk("R10 upd_pending", 32'(upd_pending), 32'd0);
    chk("R10 wr_err", 32'(wr_err), 32'd0);
    chk("R10 rs_valid", 32'(rs_valid), 32'd0);
    chk("R7 gated at reset", 32'(pwr_gated), 32'd1);
    rd_chk("R10 zero contents", 0, 0, 0);
    rd_chk("R10 zero contents", 2, 63, 1);
    // R6: frame start without request
    frame_start = 1; @(negedge clk); frame_start = 0;
    chk("R6 no flip without request", 32'(active_bank), 32'd0);
    // R7 power up timing
    power_up("R7 power-up delay");
    // R1 full load into shadow
    sweep_write(1);
    rd_chk("R5 active unaffected", 0, 3, 0);
    rd_chk("R5 active unaffected", 2, 40, 2);
    chk("R8 no error on valid writes", 32'(wr_err), 32'd0);
    flip();
    sweep_read();
    // second load with partial pair writes
    sweep_write(2);
    wr(0, 5, 1, 16'h1234, 1'b1, 16'h5555, 1'b0);   // R1 odd enable clear
    wr(2, 32, 0, 16'h6666, 1'b0, 16'hBEEF, 1'b1);  // R1 even enable clear
    // R7 regate, R8 dropped write
    pwr_dis = 0;
    @(negedge clk);
    chk("R7 regate one edge", 32'(pwr_gated), 32'd1);
    powered = 1'b0;
    wr(1, 7, 0, 16'h7777, 1'b1, 16'h7777, 1'b1);
    chk("R8 gated write flagged", 32'(wr_err), 32'd1);
    power_up("R7 power-up delay again");
    flip();
    sweep_read();
    // R6 same-cycle re-arm
    @(negedge clk); upd_req = 1;
    @(negedge clk); frame_start = 1;
    @(negedge clk); upd_req = 0; frame_start = 0;
    act = !act;
    chk("R6 flip with re-arm", 32'(active_bank), 32'(act));
    chk("R6 re-armed pending", 32'(upd_pending), 32'd1);
    frame_start = 1; @(negedge clk); frame_start = 0;
    act = !act;
    chk("R6 second flip", 32'(active_bank), 32'(act));
    chk("R6 pending consumed", 32'(upd_pending), 32'd0);
    // R9 back-pressure
    rs_ready = 0; rd_valid = 1; rd_ch = 0; rd_phase = 1; rd_tap = 0;
    @(negedge clk);
    chk("R9 first response", 32'(rs_coef), 32'(mdl[act][0][1][0]));
    chk("R9 ready low when stalled", 32'(rd_ready), 32'd0);
    rd_phase = 2; rd_tap = 1;
    @(negedge clk);
    chk("R9 held valid", 32'(rs_valid), 32'd1);
    chk("R9 held coef", 32'(rs_coef), 32'(mdl[act][0][1][0]));
    rs_ready = 1;
    @(negedge clk);
    rd_valid = 0;
    chk("R9 next response", 32'(rs_coef), 32'(mdl[act][0][2][1]));
    @(negedge clk);
    chk("R9 drained", 32'(rs_valid), 32'd0);
    // R8 out-of-range phase after fresh reset
    do_reset();
    power_up("R7 power-up after reset");
    wr(0, 40, 0, 16'h4242, 1'b1, 16'h4242, 1'b1);
    chk("R8 phase above 32 flagged", 32'(wr_err), 32'd1);
    flip();
    rd_chk("R8 dropped write left zero", 0, 24, 0);
    rd_chk("R8 dropped write left zero", 0, 40, 0);
    finish_run();
  end
endmodule